// File: doc/BRIEF.md
# Serial Audio Port Formatter

This block moves one stereo pair of 24-bit samples across a three-wire serial audio link whose bit clock (64 per frame) and word clock (one per frame) come from an external master. The transmit side accepts a left/right pair from the core at any time. It holds the pair until the next left half-frame begins, then shifts each word out MSB first on one data line. The receive side samples the incoming data line with the same settings and hands a completed pair back to the core with a one-cycle valid pulse.

Both links run in the core clock domain. The core clock oversamples the bit clock, the word clock and the receive data through a short synchroniser, then turns bit-clock edges into launch and capture strobes. Four static settings select the link format: the alignment of the word within its 32-slot half-frame, the word length used by right-justified alignment, which word-clock level marks the left channel, and which bit-clock edge launches data.

Top module: `audio_serial_port`

## Requirements
- R1: After reset, txData, rxValid, rxLeft and rxRight are all 0.
- R2: With cfgFormat = 00 (left-justified), the sample MSB occupies slot 0 of its half-frame, the 24 bits fill slots 0 to 23, and slots 24 to 31 carry 0.
- R3: With cfgFormat = 10 (one-bit delay), slot 0 carries 0, the sample MSB occupies slot 1, the 24 bits fill slots 1 to 24, and slots 25 to 31 carry 0.
- R4: With cfgFormat = 01 (right-justified), cfgWordLen codes 00, 01, 10 and 11 select 24, 20, 18 and 16 bit words. The word is the most significant bits of the sample, and its LSB falls in slot 31. Every slot before the word carries 0.
- R5: cfgWordLen has no effect when cfgFormat is 00 or 10, and cfgFormat = 11 behaves exactly like 00.
- R6: With cfgWclkPol = 0 the left channel is sent while the word clock is low. With cfgWclkPol = 1 it is sent while the word clock is high. The other level carries the right channel.
- R7: With cfgBclkPol = 0 data is launched on falling bit-clock edges and captured on rising ones. With cfgBclkPol = 1 the edges are swapped.
- R8: A pair written with txWrite is first sent in the left half-frame that starts after the write. A write during a frame does not alter that frame's right half. When no new pair is written, the last pair is sent again.
- R9: The receiver captures each half-frame with the same format settings and raises rxValid for one cycle after the last slot of the right half. rxLeft and rxRight hold the 24-bit words, which are left-aligned, with the bits below a right-justified word length set to 0. The outputs change only with rxValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the link |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFormat | input | 2 | Alignment: 00 left-justified, 10 one-bit delay, 01 right-justified, 11 as 00 |
| cfgWordLen | input | 2 | Right-justified word length: 00=24, 01=20, 10=18, 11=16 |
| cfgWclkPol | input | 1 | Word-clock level that marks the left half |
| cfgBclkPol | input | 1 | 0: launch on falling edge, 1: launch on rising edge |
| bclkIn | input | 1 | External bit clock, 64 per frame |
| wclkIn | input | 1 | External word clock |
| txLeft | input | 24 | Left sample to send |
| txRight | input | 24 | Right sample to send |
| txWrite | input | 1 | Stores txLeft/txRight as the next pair |
| txData | output | 1 | Serial data out |
| rxData | input | 1 | Serial data in |
| rxLeft | output | 24 | Last received left word |
| rxRight | output | 24 | Last received right word |
| rxValid | output | 1 | One-cycle pulse when a received pair is ready |

## Verification
On every cycle, the assertions check four things: the serial output moves only just after a launch strobe, the held right sample changes only at a left half-frame start, right-justified words load with zero leading slots, and the receive outputs change only with a single-cycle valid pulse that follows a finished right half. The exact slot position of every bit under each alignment, word length and polarity can only be shown by the bench scenarios. The same holds for word-length values being ignored outside right-justified mode and for a pair written mid-frame being deferred to the next frame.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'b00,
    FMT_RIGHT = 2'b01,
    FMT_DELAY = 2'b10,
    FMT_ALT   = 2'b11
  } align_e;

  // Strobes from the link control to the datapath, one core cycle wide.
  typedef struct packed {
    logic launch;     // active launch edge of the bit clock
    logic capture;    // active capture edge of the bit clock
    logic boundary;   // launch edge that opens a new half-frame
    logic frameStart; // boundary that opens a left half-frame
    logic newLeft;    // half opened by this boundary is the left one
    logic curLeft;    // half currently in progress is the left one
    logic halfDone;   // capture of the last slot of a complete half
  } strobe_t;

  // Right-justified word length for a given length code.
  function automatic int unsigned rjLen(input logic [1:0] code, input int unsigned full);
    case (code)
      2'b00:   return full;
      2'b01:   return full - 4;
      2'b10:   return full - 6;
      default: return full - 8;
    endcase
  endfunction

endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int HALF_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bclkIn,
  input  logic    wclkIn,
  input  logic    rxDataIn,
  input  logic    cfgWclkPol,
  input  logic    cfgBclkPol,
  output strobe_t strobe,
  output logic    rxBit
);

  localparam int SLOT_W = $clog2(HALF_BITS) + 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(HALF_BITS - 1);

  logic [2:0] syncOut;
  logic bclkS, wclkS;
  logic bclkPrev;
  logic rise, fall, launch, capture, leftNow, boundary;
  logic primed, wclkLast, halfLeft, halfGood;
  logic [SLOT_W-1:0] slot;

  asp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bclkIn, wclkIn, rxDataIn}),
    .dout (syncOut)
  );

  assign bclkS = syncOut[2];
  assign wclkS = syncOut[1];
  assign rxBit = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bclkPrev <= 1'b0;
    else       bclkPrev <= bclkS;
  end

  always_comb begin
    rise     = bclkS & ~bclkPrev;
    fall     = ~bclkS & bclkPrev;
    launch   = cfgBclkPol ? rise : fall;
    capture  = cfgBclkPol ? fall : rise;
    leftNow  = (wclkS == cfgWclkPol);
    boundary = launch && (wclkS != wclkLast);
  end

  // Word-clock level tracking: follows every cycle until the first launch
  // edge, then only at launch edges so the first real transition is seen.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      wclkLast <= 1'b0;
    end else begin
      if (launch || !primed) wclkLast <= wclkS;
      if (launch)            primed   <= 1'b1;
    end
  end

  // Slot counter within the half-frame, saturating on an over-long half.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot     <= '0;
      halfLeft <= 1'b0;
      halfGood <= 1'b0;
    end else if (boundary) begin
      slot     <= '0;
      halfLeft <= leftNow;
      halfGood <= 1'b1;
    end else if (launch && slot != '1) begin
      slot <= slot + 1'b1;
    end
  end

  always_comb begin
    strobe.launch     = launch;
    strobe.capture    = capture;
    strobe.boundary   = boundary;
    strobe.frameStart = boundary && leftNow;
    strobe.newLeft    = leftNow;
    strobe.curLeft    = halfLeft;
    strobe.halfDone   = capture && halfGood && (slot == LAST_SLOT);
  end

endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int HALF_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgFormat,
  input  logic [1:0]          cfgWordLen,
  input  strobe_t             strobe,
  input  logic                rxBit,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  input  logic                txWrite,
  output logic                txData,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  localparam int PAD = HALF_BITS - SAMPLE_W;

  logic [SAMPLE_W-1:0]  pendL, pendR, activeR, heldL;
  logic [HALF_BITS-1:0] txShift;
  logic [HALF_BITS-2:0] rxShift;
  logic [HALF_BITS-1:0] rxFull;
  logic [SAMPLE_W-1:0]  rxWord;
  logic                 gotLeft;

  // Place a sample in its half-frame, slot 0 at the MSB end.
  function automatic logic [HALF_BITS-1:0] alignWord(input logic [1:0] fmt,
                                                     input logic [1:0] wl,
                                                     input logic [SAMPLE_W-1:0] s);
    logic [HALF_BITS-1:0] ext;
    ext = {{PAD{1'b0}}, s};
    case (align_e'(fmt))
      FMT_RIGHT: alignWord = ext >> (SAMPLE_W - rjLen(wl, SAMPLE_W));
      FMT_DELAY: alignWord = ext << (PAD - 1);
      default:   alignWord = ext << PAD;
    endcase
  endfunction

  // Recover a left-aligned sample from a received half-frame.
  function automatic logic [SAMPLE_W-1:0] extractWord(input logic [1:0] fmt,
                                                      input logic [1:0] wl,
                                                      input logic [HALF_BITS-1:0] full);
    logic [SAMPLE_W-1:0] low;
    low = full[SAMPLE_W-1:0];
    case (align_e'(fmt))
      FMT_RIGHT: extractWord = low << (SAMPLE_W - rjLen(wl, SAMPLE_W));
      FMT_DELAY: extractWord = full[HALF_BITS-2 -: SAMPLE_W];
      default:   extractWord = full[HALF_BITS-1 -: SAMPLE_W];
    endcase
  endfunction

  // Transmit holding: the pending pair is taken at a left half start;
  // the right word waits in activeR for its own half.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendL   <= '0;
      pendR   <= '0;
      activeR <= '0;
    end else begin
      if (txWrite)           {pendL, pendR} <= {txLeft, txRight};
      if (strobe.frameStart) activeR        <= pendR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txShift <= '0;
    else if (strobe.boundary) txShift <= alignWord(cfgFormat, cfgWordLen,
                                                   strobe.newLeft ? pendL : activeR);
    else if (strobe.launch)   txShift <= txShift << 1;
  end

  assign txData = txShift[HALF_BITS-1];

  // Receive path.
  assign rxFull = {rxShift, rxBit};
  assign rxWord = extractWord(cfgFormat, cfgWordLen, rxFull);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxShift <= '0;
    else if (strobe.capture) rxShift <= rxFull[HALF_BITS-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldL   <= '0;
      gotLeft <= 1'b0;
      rxLeft  <= '0;
      rxRight <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.frameStart) gotLeft <= 1'b0;
      if (strobe.halfDone) begin
        if (strobe.curLeft) begin
          heldL   <= rxWord;
          gotLeft <= 1'b1;
        end else if (gotLeft) begin
          rxLeft  <= heldL;
          rxRight <= rxWord;
          rxValid <= 1'b1;
          gotLeft <= 1'b0;
        end
      end
    end
  end

  // Serial output moves only right after a launch strobe from the control.
  assert_tx_on_launch_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txData) |-> $past(strobe.launch));

  // The held right word changes only at a left half-frame start.
  assert_pair_latch_left_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeR) |-> $past(strobe.frameStart));

  // Right-justified load leaves every slot ahead of the word at zero.
  assert_rj_leading_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.boundary) && $past(cfgFormat) == 2'b01)
      |-> ((txShift >> rjLen($past(cfgWordLen), SAMPLE_W)) == '0));

  // A received pair is reported only after a finished right half.
  assert_rx_after_right_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ($past(strobe.halfDone) && !$past(strobe.curLeft)));

  assert_rx_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rxLeft) || !$stable(rxRight)) |-> rxValid);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int HALF_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgFormat,
  input  logic [1:0]          cfgWordLen,
  input  logic                cfgWclkPol,
  input  logic                cfgBclkPol,
  input  logic                bclkIn,
  input  logic                wclkIn,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  input  logic                txWrite,
  output logic                txData,
  input  logic                rxData,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  strobe_t strobe;
  logic    rxBit;

  asp_ctrl #(.HALF_BITS(HALF_BITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bclkIn     (bclkIn),
    .wclkIn     (wclkIn),
    .rxDataIn   (rxData),
    .cfgWclkPol (cfgWclkPol),
    .cfgBclkPol (cfgBclkPol),
    .strobe     (strobe),
    .rxBit      (rxBit)
  );

  asp_datapath #(.SAMPLE_W(SAMPLE_W), .HALF_BITS(HALF_BITS)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .cfgFormat  (cfgFormat),
    .cfgWordLen (cfgWordLen),
    .strobe     (strobe),
    .rxBit      (rxBit),
    .txLeft     (txLeft),
    .txRight    (txRight),
    .txWrite    (txWrite),
    .txData     (txData),
    .rxLeft     (rxLeft),
    .rxRight    (rxRight),
    .rxValid    (rxValid)
  );

endmodule

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [1:0]  bits = 2'b00;
  logic        wp = 1'b0;
  logic        bp = 1'b0;
  logic        bclk = 1'b1;
  logic        wclk = 1'b1;
  logic [23:0] txLeft = '0;
  logic [23:0] txRight = '0;
  logic        txWrite = 1'b0;
  logic        txData;
  logic        sdin = 1'b0;
  logic [23:0] rxLeft, rxRight;
  logic        rxValid;

  int nChecks = 0;
  int nFails = 0;
  int rxCount = 0;
  logic [23:0] gotL = '0, gotR = '0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_serial_port dut (
    .clk(clk), .rstN(rstN), .cfgFormat(fmt), .cfgWordLen(bits),
    .cfgWclkPol(wp), .cfgBclkPol(bp), .bclkIn(bclk), .wclkIn(wclk),
    .txLeft(txLeft), .txRight(txRight), .txWrite(txWrite), .txData(txData),
    .rxData(sdin), .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      rxCount++;
      gotL = rxLeft;
      gotR = rxRight;
    end
  end

  function automatic int lenOf(input logic [1:0] b);
    case (b)
      2'b00:   return 24;
      2'b01:   return 20;
      2'b10:   return 18;
      default: return 16;
    endcase
  endfunction

  // Expected line value for one slot of a half-frame.
  function automatic logic expBit(input logic [1:0] f, input logic [1:0] b,
                                  input logic [23:0] s, input int slot);
    int len;
    len = lenOf(b);
    if (f == 2'b01) return (slot >= 32 - len) ? s[23 - (slot - (32 - len))] : 1'b0;
    if (f == 2'b10) return (slot >= 1 && slot <= 24) ? s[24 - slot] : 1'b0;
    return (slot < 24) ? s[23 - slot] : 1'b0;
  endfunction

  function automatic logic [23:0] expRx(input logic [1:0] f, input logic [1:0] b,
                                        input logic [23:0] s);
    int sh;
    sh = 24 - lenOf(b);
    if (f == 2'b01) return (s >> sh) << sh;
    return s;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic writePair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    txLeft = l; txRight = r; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  // One frame of 64 slots, 16 core cycles per slot.
  task automatic runFrame(input string tag, input bit doCheck,
                          input logic [23:0] expL, input logic [23:0] expR,
                          input logic [23:0] drvL, input logic [23:0] drvR,
                          input int wrSlot, input logic [23:0] wrL, input logic [23:0] wrR);
    logic launchLvl, leftLvl;
    launchLvl = bp;
    leftLvl   = wp;
    rxCount   = 0;
    for (int slot = 0; slot < 64; slot++) begin
      @(negedge clk);
      bclk = launchLvl;
      if (slot == 0)  wclk = leftLvl;
      if (slot == 32) wclk = ~leftLvl;
      sdin = expBit(fmt, bits, (slot < 32) ? drvL : drvR, slot % 32);
      if (slot == wrSlot) begin
        txLeft = wrL; txRight = wrR; txWrite = 1'b1;
        @(negedge clk);
        txWrite = 1'b0;
        repeat (6) @(negedge clk);
      end else begin
        repeat (7) @(negedge clk);
      end
      if (doCheck)
        check(tag, $sformatf("tx slot %0d", slot), {31'd0, txData},
              {31'd0, expBit(fmt, bits, (slot < 32) ? expL : expR, slot % 32)});
      @(negedge clk);
      bclk = ~launchLvl;
      repeat (7) @(negedge clk);
    end
    if (doCheck) begin
      check("R9", "rx pair count", rxCount, 1);
      check("R9", "rx left", {8'd0, gotL}, {8'd0, expRx(fmt, bits, drvL)});
      check("R9", "rx right", {8'd0, gotR}, {8'd0, expRx(fmt, bits, drvR)});
    end
  endtask

  // New settings, idle levels, then one unchecked frame to settle.
  task automatic setCfg(input logic [1:0] f, input logic [1:0] b, input logic w, input logic p);
    @(negedge clk);
    fmt = f; bits = b; wp = w; bp = p;
    bclk = ~p;
    wclk = ~w;
    repeat (20) @(negedge clk);
    runFrame("warm", 0, '0, '0, '0, '0, -1, '0, '0);
  endtask

  task automatic testReset();
    check("R1", "txData", {31'd0, txData}, 0);
    check("R1", "rxValid", {31'd0, rxValid}, 0);
    check("R1", "rxLeft", {8'd0, rxLeft}, 0);
    check("R1", "rxRight", {8'd0, rxRight}, 0);
  endtask

  task automatic testLeftJustified();
    writePair(24'hA5C3E1, 24'h5A3C1E);
    setCfg(2'b00, 2'b00, 1'b0, 1'b0);
    runFrame("R2", 1, 24'hA5C3E1, 24'h5A3C1E, 24'hF0F00F, 24'h0FF0F1, -1, '0, '0);
    runFrame("R2", 1, 24'hA5C3E1, 24'h5A3C1E, 24'h800001, 24'hFFFFFF, -1, '0, '0);
  endtask

  task automatic testDelayed();
    writePair(24'hC00003, 24'h812345);
    setCfg(2'b10, 2'b00, 1'b0, 1'b0);
    runFrame("R3", 1, 24'hC00003, 24'h812345, 24'h9ABCDE, 24'h13579B, -1, '0, '0);
  endtask

  task automatic testRightJustified();
    writePair(24'hB7D95F, 24'hE3A1C9);
    for (int b = 0; b < 4; b++) begin
      setCfg(2'b01, 2'(b), 1'b0, 1'b0);
      runFrame("R4", 1, 24'hB7D95F, 24'hE3A1C9, 24'hFEDCBB, 24'h6BCDEF, -1, '0, '0);
    end
  endtask

  task automatic testWordLenIgnored();
    writePair(24'h3C5A69, 24'hD2B4F7);
    setCfg(2'b00, 2'b11, 1'b0, 1'b0);
    runFrame("R5", 1, 24'h3C5A69, 24'hD2B4F7, 24'hA1B2C3, 24'h4D5E6F, -1, '0, '0);
    setCfg(2'b10, 2'b01, 1'b0, 1'b0);
    runFrame("R5", 1, 24'h3C5A69, 24'hD2B4F7, 24'hA1B2C3, 24'h4D5E6F, -1, '0, '0);
    setCfg(2'b11, 2'b10, 1'b0, 1'b0);
    runFrame("R5", 1, 24'h3C5A69, 24'hD2B4F7, 24'h77889B, 24'hCCDDEF, -1, '0, '0);
  endtask

  task automatic testWclkPolarity();
    writePair(24'h0F1E2D, 24'hF1E2D3);
    setCfg(2'b00, 2'b00, 1'b1, 1'b0);
    runFrame("R6", 1, 24'h0F1E2D, 24'hF1E2D3, 24'h55AA33, 24'hAA55CC, -1, '0, '0);
  endtask

  task automatic testBclkPolarity();
    writePair(24'h96C3A5, 24'h1248F1);
    setCfg(2'b00, 2'b00, 1'b0, 1'b1);
    runFrame("R7", 1, 24'h96C3A5, 24'h1248F1, 24'hE7D6C5, 24'h3B2A19, -1, '0, '0);
    setCfg(2'b10, 2'b00, 1'b1, 1'b1);
    runFrame("R7", 1, 24'h96C3A5, 24'h1248F1, 24'h2468AD, 24'hFDB975, -1, '0, '0);
  endtask

  task automatic testLatch();
    writePair(24'hABCDEF, 24'h876543);
    setCfg(2'b00, 2'b00, 1'b0, 1'b0);
    // Write in the left half: this frame keeps the old right word.
    runFrame("R8", 1, 24'hABCDEF, 24'h876543, 24'h112233, 24'h445567, 10, 24'h5EC0D1, 24'hE1F203);
    runFrame("R8", 1, 24'h5EC0D1, 24'hE1F203, 24'h998877, 24'h665545, -1, '0, '0);
    // No write: the same pair is sent again.
    runFrame("R8", 1, 24'h5EC0D1, 24'hE1F203, 24'h0A0B0C, 24'hD0E0F1, -1, '0, '0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testLeftJustified();
    testDelayed();
    testRightJustified();
    testWordLenIgnored();
    testWclkPolarity();
    testBclkPolarity();
    testLatch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule